// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reset request on the chip and turns it into an ordered release of reset to a set of clock domains. Four sources can start a sequence: the asynchronous power-on reset, an external reset pin that has already been filtered, a watchdog timeout and a single-cycle software request. Once any source fires, every domain goes into reset. The domains then leave reset one after another at fixed intervals. A power-on reset adds a long extension before the first domain is released, so that supplies and clocks can settle.

The block also produces several side outputs. `por_rst_no` resets only the state that must survive resets other than power-on. A sticky cause field records which sources have fired; software clears it bit by bit with write-one-to-clear. `boot_hold_o` tells the boot-mode logic to keep its current bit after a watchdog or software reset. The block also holds a small bank of general-purpose registers that only power-on reset clears.

Top module: `rst_seq`

## Requirements
- R1: While `rst_ni` is low, all domain resets are low, `por_rst_no` is low, `cause_o` reads 4'b0001, `boot_hold_o` is 0 and every general-purpose register reads 0.
- R2: The pin reset passes through a two-flop synchronizer. The watchdog and software inputs are each registered once. A pin that is low at edge E puts every domain back into reset at edge E+2. A watchdog or software pulse sampled at edge A does so at edge A+1.
- R3: After the edge that starts a sequence, domain k (k = 0,1,2) leaves reset exactly PH_CYC*(k+1) edges later. Domains release in ascending order, and no two are released on the same edge.
- R4: After `rst_ni` rises, `por_rst_no` and all domains stay low for POR_CYC edges. `por_rst_no` then rises and the phased release of R3 follows. After that, only `rst_ni` can drive `por_rst_no` low again.
- R5: A new trigger during a sequence restarts the sequence from its first cycle. A trigger during the power-on extension restarts the full POR_CYC extension.
- R6: `cause_o` bit 0 marks power-on, bit 1 the pin, bit 2 the watchdog and bit 3 software. A source's bit is set on the edge that restarts the sequence. Bits accumulate until they are cleared.
- R7: A one in `cause_clr_i` clears that cause bit on the next edge. If a bit is set and cleared on the same edge, the set wins.
- R8: `boot_hold_o` becomes 1 when a watchdog or software reset starts from the running state. It becomes 0 on a pin reset or a power-on reset. A watchdog or software trigger that arrives during a sequence leaves it unchanged.
- R9: The general-purpose registers are written through `gp_we_i`/`gp_addr_i`/`gp_wdata_i` and read combinationally on `gp_rdata_o`. Pin, watchdog and software resets leave their contents unchanged.
- R10: While the pin is held low, every domain stays in reset. The last restart happens on the second edge after the pin rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_ni | input | 1 | Filtered external reset pin, active low |
| wdog_rst_i | input | 1 | Watchdog timeout request |
| sw_rst_i | input | 1 | Software reset request, one-cycle pulse |
| cause_clr_i | input | 4 | Write-one-to-clear mask for the cause field |
| gp_we_i | input | 1 | General-purpose register write enable |
| gp_addr_i | input | 2 | General-purpose register select |
| gp_wdata_i | input | 16 | General-purpose register write data |
| gp_rdata_o | output | 16 | Selected general-purpose register |
| dom_rst_no | output | 3 | Per-domain reset, active low, bit k is domain k |
| por_rst_no | output | 1 | Reset for state kept across non-power-on resets, active low |
| cause_o | output | 4 | Sticky reset cause field |
| boot_hold_o | output | 1 | Keep the boot-mode bit unchanged |

## Verification
The hardest case to reach is a second trigger that lands inside a running sequence, especially one that lands inside the power-on extension. The restart, the rule for the extension length and the hold of `boot_hold_o` all have to be right at once. The bench lets a sequence run partway, until some domains are already released, and then fires a second source. It does the same in the middle of the power-on extension, and then counts the full release again from the new start. A software pulse paired with a clear of its own cause bit on the same edge exercises the set-over-clear priority.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned C_POR  = 0;
  localparam int unsigned C_PIN  = 1;
  localparam int unsigned C_WDOG = 2;
  localparam int unsigned C_SW   = 3;

  typedef enum logic [1:0] {
    SEQ_EXTEND = 2'd0,
    SEQ_PHASE  = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rst_src_sync.sv
module rst_src_sync
  import rst_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_rst_ni,
  input  logic               wdog_rst_i,
  input  logic               sw_rst_i,
  output logic [CAUSE_W-1:0] hit_o
);
  logic [1:0] pin_sync_q;
  logic       wdog_q;
  logic       sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_sync_q <= 2'b11;
      wdog_q     <= 1'b0;
      sw_q       <= 1'b0;
    end else begin
      pin_sync_q <= {pin_sync_q[0], pin_rst_ni};
      wdog_q     <= wdog_rst_i;
      sw_q       <= sw_rst_i;
    end
  end

  always_comb begin
    hit_o         = '0;
    hit_o[C_PIN]  = ~pin_sync_q[1];
    hit_o[C_WDOG] = wdog_q;
    hit_o[C_SW]   = sw_q;
  end
endmodule

// File: rtl/rst_phase_ctrl.sv
module rst_phase_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYC = 2**21,
  parameter int unsigned PH_CYC  = 32,
  parameter int unsigned NUM_DOM = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  output logic [NUM_DOM-1:0] dom_rst_no,
  output logic               por_done_o,
  output logic               idle_o
);
  localparam int unsigned MAX_CYC = (POR_CYC > PH_CYC) ? POR_CYC : PH_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned PH_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYC - 1);
  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PH_CYC - 1);
  localparam logic [PH_W-1:0]  DOM_LAST = PH_W'(NUM_DOM - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             por_q, por_d;
  logic             step_end;

  assign step_end = (state_q == SEQ_PHASE) && (cnt_q == PH_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    por_d   = por_q;
    if (trig_i) begin
      // restart; an unfinished power-on extension keeps its long length
      cnt_d   = '0;
      ph_d    = '0;
      state_d = (state_q == SEQ_EXTEND) ? SEQ_EXTEND : SEQ_PHASE;
    end else begin
      case (state_q)
        SEQ_EXTEND: begin
          if (cnt_q == POR_LAST) begin
            cnt_d   = '0;
            state_d = SEQ_PHASE;
            por_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_PHASE: begin
          if (step_end) begin
            cnt_d = '0;
            if (ph_q == DOM_LAST) state_d = SEQ_RUN;
            else                  ph_d    = ph_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_EXTEND;
      cnt_q   <= '0;
      ph_q    <= '0;
      por_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      por_q   <= por_d;
    end
  end

  for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
    logic rel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 rel_q <= 1'b0;
      else if (trig_i)                             rel_q <= 1'b0;
      else if (step_end && ph_q == PH_W'(k))       rel_q <= 1'b1;
    end
    assign dom_rst_no[k] = rel_q;
  end

  assign por_done_o = por_q;
  assign idle_o     = (state_q == SEQ_RUN);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] hit_i,
  input  logic [CAUSE_W-1:0] clr_i,
  input  logic               idle_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               boot_hold_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic               hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_W'(1) << C_POR;
      hold_q  <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~clr_i) | hit_i;  // set beats clear
      if (hit_i[C_PIN])
        hold_q <= 1'b0;
      else if ((hit_i[C_WDOG] || hit_i[C_SW]) && idle_i)
        hold_q <= 1'b1;
    end
  end

  assign cause_o     = cause_q;
  assign boot_hold_o = hold_q;
endmodule

// File: rtl/rst_gp_bank.sv
module rst_gp_bank #(
  parameter int unsigned NUM = 4,
  parameter int unsigned W   = 16,
  localparam int unsigned AW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [NUM-1:0][W-1:0] regs;

  for (genvar k = 0; k < NUM; k++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (we_i && addr_i == AW'(k))   q <= wdata_i;
    end
    assign regs[k] = q;
  end

  assign rdata_o = regs[addr_i];
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned POR_CYC = 2**21,
  parameter int unsigned PH_CYC  = 32,
  parameter int unsigned NUM_DOM = 3,
  parameter int unsigned GP_NUM  = 4,
  parameter int unsigned GP_W    = 16,
  localparam int unsigned GP_AW  = (GP_NUM > 1) ? $clog2(GP_NUM) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_rst_ni,
  input  logic               wdog_rst_i,
  input  logic               sw_rst_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  input  logic               gp_we_i,
  input  logic [GP_AW-1:0]   gp_addr_i,
  input  logic [GP_W-1:0]    gp_wdata_i,
  output logic [GP_W-1:0]    gp_rdata_o,
  output logic [NUM_DOM-1:0] dom_rst_no,
  output logic               por_rst_no,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               boot_hold_o
);
  logic [CAUSE_W-1:0] hit;
  logic               trig;
  logic               idle;

  rst_src_sync u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_rst_ni (pin_rst_ni),
    .wdog_rst_i (wdog_rst_i),
    .sw_rst_i   (sw_rst_i),
    .hit_o      (hit)
  );

  assign trig = |hit;

  rst_phase_ctrl #(
    .POR_CYC (POR_CYC),
    .PH_CYC  (PH_CYC),
    .NUM_DOM (NUM_DOM)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .dom_rst_no (dom_rst_no),
    .por_done_o (por_rst_no),
    .idle_o     (idle)
  );

  rst_cause_reg u_cause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .clr_i       (cause_clr_i),
    .idle_i      (idle),
    .cause_o     (cause_o),
    .boot_hold_o (boot_hold_o)
  );

  rst_gp_bank #(
    .NUM (GP_NUM),
    .W   (GP_W)
  ) u_gp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (gp_we_i),
    .addr_i  (gp_addr_i),
    .wdata_i (gp_wdata_i),
    .rdata_o (gp_rdata_o)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int unsigned NUM_DOM = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pin_rst_ni,
  input logic               wdog_rst_i,
  input logic               sw_rst_i,
  input logic [NUM_DOM-1:0] dom_rst_no,
  input logic               por_rst_no,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               boot_hold_o
);
  for (genvar k = 1; k < NUM_DOM; k++) begin : g_order
    AST_PHASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dom_rst_no[k] |-> dom_rst_no[k-1]); // R3
  end

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dom_rst_no & ~$past(dom_rst_no))); // R3

  AST_SW_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> ##2 (dom_rst_no == '0)); // R2

  AST_WDOG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_i |-> ##2 (dom_rst_no == '0)); // R2

  AST_PIN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rst_ni |-> ##3 (dom_rst_no == '0)); // R10

  AST_POR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_rst_no |=> por_rst_no); // R4

  AST_POR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom_rst_no != '0) |-> por_rst_no); // R4

  AST_CAUSE_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> ##2 cause_o[C_SW]); // R6

  AST_HOLD_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rst_ni |-> ##3 !boot_hold_o); // R8
endmodule

bind rst_seq rst_seq_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_rst_ni  (pin_rst_ni),
  .wdog_rst_i  (wdog_rst_i),
  .sw_rst_i    (sw_rst_i),
  .dom_rst_no  (dom_rst_no),
  .por_rst_no  (por_rst_no),
  .cause_o     (cause_o),
  .boot_hold_o (boot_hold_o)
);

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam time CLK_PERIOD = 10;
  localparam int POR_CYC = 40;
  localparam int PH_CYC  = 8;
  localparam int NUM_DOM = 3;
  localparam int GP_NUM  = 4;
  localparam int GP_W    = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_ni = 1'b0;
  logic              pin_rst_ni = 1'b1;
  logic              wdog_rst_i = 1'b0;
  logic              sw_rst_i = 1'b0;
  logic [3:0]        cause_clr_i = '0;
  logic              gp_we_i = 1'b0;
  logic [1:0]        gp_addr_i = '0;
  logic [GP_W-1:0]   gp_wdata_i = '0;
  logic [GP_W-1:0]   gp_rdata_o;
  logic [NUM_DOM-1:0] dom_rst_no;
  logic              por_rst_no;
  logic [3:0]        cause_o;
  logic              boot_hold_o;

  rst_seq #(.POR_CYC(POR_CYC), .PH_CYC(PH_CYC), .NUM_DOM(NUM_DOM),
            .GP_NUM(GP_NUM), .GP_W(GP_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_rst_ni(pin_rst_ni),
    .wdog_rst_i(wdog_rst_i), .sw_rst_i(sw_rst_i), .cause_clr_i(cause_clr_i),
    .gp_we_i(gp_we_i), .gp_addr_i(gp_addr_i), .gp_wdata_i(gp_wdata_i),
    .gp_rdata_o(gp_rdata_o), .dom_rst_no(dom_rst_no), .por_rst_no(por_rst_no),
    .cause_o(cause_o), .boot_hold_o(boot_hold_o));

  int checks = 0;
  int fails  = 0;
  logic [GP_W-1:0] gp_model [GP_NUM];
  logic [3:0] exp_cause;
  logic       exp_hold;

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NUM_DOM-1:0] rel_mask(input int n);
    return NUM_DOM'((1 << n) - 1);
  endfunction

  function automatic logic [3:0] src_bit(input int kind);
    return 4'b0010 << kind;  // 0 pin, 1 watchdog, 2 software
  endfunction

  // caller stands at the negedge just after the restart edge
  task automatic watch_phases(input string req);
    for (int k = 0; k < NUM_DOM; k++) begin
      repeat (PH_CYC-1) @(negedge clk);
      chk_eq(req, dom_rst_no, rel_mask(k));
      @(negedge clk);
      chk_eq(req, dom_rst_no, rel_mask(k+1));
    end
  endtask

  task automatic watch_extension(input string req);
    repeat (POR_CYC-1) @(negedge clk);
    chk_eq(req, {dom_rst_no, por_rst_no}, '0);
    @(negedge clk);
    chk_eq(req, por_rst_no, 1'b1);
    chk_eq(req, dom_rst_no, '0);
  endtask

  task automatic check_gp(input string req);
    for (int a = 0; a < GP_NUM; a++) begin
      gp_addr_i = 2'(a);
      #1;
      chk_eq(req, gp_rdata_o, gp_model[a]);
    end
  endtask

  task automatic gp_write(input int a, input logic [GP_W-1:0] d);
    gp_we_i = 1'b1; gp_addr_i = 2'(a); gp_wdata_i = d;
    @(negedge clk);
    gp_we_i = 1'b0;
    gp_model[a] = d;
  endtask

  // ends at the negedge just after the restart edge
  task automatic fire(input int kind, input bit from_idle);
    case (kind)
      0: pin_rst_ni = 1'b0;
      1: wdog_rst_i = 1'b1;
      default: sw_rst_i = 1'b1;
    endcase
    @(negedge clk);
    pin_rst_ni = 1'b1; wdog_rst_i = 1'b0; sw_rst_i = 1'b0;
    repeat ((kind == 0) ? 2 : 1) @(negedge clk);
    exp_cause = exp_cause | src_bit(kind);
    if (kind == 0) exp_hold = 1'b0;
    else if (from_idle) exp_hold = 1'b1;
  endtask

  task automatic power_on();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < GP_NUM; a++) gp_model[a] = '0;
    exp_cause = 4'b0001; exp_hold = 1'b0;
    chk_eq("R1 domains", dom_rst_no, '0);
    chk_eq("R1 por", por_rst_no, 1'b0);
    chk_eq("R1 cause", cause_o, exp_cause);
    chk_eq("R1 hold", boot_hold_o, 1'b0);
    check_gp("R1 gp");
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // power-on, long extension then phased release
    power_on();
    watch_extension("R4 extension");
    watch_phases("R3 release after por");

    // software reset from run, gp kept
    for (int a = 0; a < GP_NUM; a++) gp_write(a, GP_W'($urandom));
    fire(2, 1'b1);
    chk_eq("R2 sw restart", dom_rst_no, '0);
    chk_eq("R6 sw cause", cause_o, exp_cause);
    chk_eq("R8 sw hold", boot_hold_o, exp_hold);
    watch_phases("R3 sw release");
    check_gp("R9 gp after sw");

    // pin reset from run
    fire(0, 1'b1);
    chk_eq("R2 pin restart", dom_rst_no, '0);
    chk_eq("R6 pin cause", cause_o, exp_cause);
    chk_eq("R8 pin hold", boot_hold_o, 1'b0);
    watch_phases("R3 pin release");

    // write-one-to-clear
    cause_clr_i = 4'b0011;
    @(negedge clk);
    cause_clr_i = '0;
    exp_cause = exp_cause & ~4'b0011;
    chk_eq("R7 clear", cause_o, exp_cause);

    // set beats clear on the same edge
    cause_clr_i = 4'b1000;
    @(negedge clk);
    cause_clr_i = '0;
    exp_cause = exp_cause & ~4'b1000;
    chk_eq("R7 clear sw bit", cause_o, exp_cause);
    sw_rst_i = 1'b1;
    @(negedge clk);
    sw_rst_i = 1'b0; cause_clr_i = 4'b1000;
    @(negedge clk);
    cause_clr_i = '0;
    exp_cause = exp_cause | 4'b1000; exp_hold = 1'b1;
    chk_eq("R7 set wins", cause_o, exp_cause);
    watch_phases("R3 after set-wins");

    // pin then software mid-sequence: restart, hold stays low
    fire(0, 1'b1);
    repeat (PH_CYC + 3) @(negedge clk);
    chk_eq("R5 partly released", dom_rst_no, rel_mask(1));
    fire(2, 1'b0);
    chk_eq("R5 restart mid-seq", dom_rst_no, '0);
    chk_eq("R8 hold mid-seq", boot_hold_o, 1'b0);
    watch_phases("R5 full release after restart");

    // pin held low
    pin_rst_ni = 1'b0;
    repeat (5 * PH_CYC) @(negedge clk);
    chk_eq("R10 held", dom_rst_no, '0);
    pin_rst_ni = 1'b1;
    @(negedge clk);
    chk_eq("R10 sync tail", dom_rst_no, '0);
    @(negedge clk);
    exp_cause = exp_cause | 4'b0010; exp_hold = 1'b0;
    watch_phases("R10 release after pin");
    chk_eq("R6 pin held cause", cause_o, exp_cause);

    // random mix from run
    for (int it = 0; it < 12; it++) begin
      int kind;
      logic [3:0] m;
      gp_write(int'($urandom_range(0, GP_NUM-1)), GP_W'($urandom));
      m = 4'($urandom);
      cause_clr_i = m;
      @(negedge clk);
      cause_clr_i = '0;
      exp_cause = exp_cause & ~m;
      chk_eq("R7 random clear", cause_o, exp_cause);
      kind = int'($urandom_range(0, 2));
      fire(kind, 1'b1);
      chk_eq("R2 random restart", dom_rst_no, '0);
      chk_eq("R6 random cause", cause_o, exp_cause);
      chk_eq("R8 random hold", boot_hold_o, exp_hold);
      watch_phases("R3 random release");
      check_gp("R9 random gp");
    end

    // trigger inside the power-on extension
    power_on();
    repeat (10) @(negedge clk);
    fire(2, 1'b0);
    chk_eq("R5 ext cause", cause_o, exp_cause);
    chk_eq("R8 ext hold", boot_hold_o, 1'b0);
    watch_extension("R5 extension restarted");
    watch_phases("R4 release after restarted extension");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule